// File: doc/BRIEF.md
# LIN Header Break and Bit-Rate Synchronizer

This block is the receive front end of a LIN responder node. It watches the serial receive line for a dominant (low) stretch that is long enough to count as a break, measured against the programmed bit period. It then times the falling edges of the 0x55 synchronization byte that follows. From that timing it derives the master's bit period, rounded to the nearest clock, and rejects the byte when its edges are uneven.

When adaptation is enabled, a successful measurement replaces the bit period used by the node. The block also has a bit sampler that splits each bit cell into sixteen sub-samples. It decides each bit by a two-of-three vote over sub-samples 8, 9 and 10, and a bit cell restarts on every falling edge of the line. Later stages use it to receive data bytes.

All periods are given in clock cycles. The receive line is registered once inside the block, and the design works on that registered copy. Every output is registered.

Top module: `lin_hdr_sync`

## Requirements
- R1: A falling edge on a high line starts a low-time count. When the line returns high after at least 11 × `nominal_period` low cycles, `break_detected` pulses high for exactly one cycle.
- R2: A low stretch shorter than 11 × `nominal_period` cycles gives no break. The block then goes back to waiting for the next falling edge, so a following 0x55 byte produces neither `sync_done` nor `sync_error`.
- R3: After a break, the high delimiter may last any number of cycles. Synch timing starts at the first falling edge after the break, which is the start bit of the synch byte.
- R4: Let the total be the number of cycles from the start-bit falling edge to the fifth falling edge, which is the edge that opens bit 7 and spans 8 bit times. The measured period is the total shifted right by 3, plus bit 2 of the total.
- R5: On a successful synch byte, `measured_period` takes the new value only when `adapt_en` is 1; otherwise it keeps its value. Its reset value is 0. `measured_period` changes at no other time.
- R6: The four falling-edge intervals each span two bits. If any interval I fails the test |4·I − total| ≤ floor(total/8), `sync_error` pulses for one cycle and `measured_period` is left unchanged. The block then waits for a new break.
- R7: Each accepted synch byte gives exactly one single-cycle pulse, either `sync_done` or `sync_error`, never both.
- R8: The bit sampler takes one sub-sample every max(1, P>>4) clocks, counting from the most recent falling edge of the registered line. P is `measured_period` when `adapt_en` is 1 and `measured_period` is non-zero; otherwise P is `nominal_period`. On the 16th sub-sample, `bit_strobe` pulses and `bit_value` is the majority of sub-samples 8, 9 and 10. The count then restarts.
- R9: While reset is held, every output is 0.
- R10: The break threshold is exact: a low stretch of 11 × `nominal_period` − 1 cycles is rejected, and one of 11 × `nominal_period` cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | LIN receive line (low is dominant) |
| nominal_period | input | PW | Programmed bit period in clock cycles |
| adapt_en | input | 1 | Enables replacement of the bit period by the measured one |
| break_detected | output | 1 | One-cycle pulse on a qualified break |
| measured_period | output | PW | Last adopted measured bit period |
| sync_done | output | 1 | One-cycle pulse on a consistent synch byte |
| sync_error | output | 1 | One-cycle pulse on an inconsistent synch byte |
| bit_value | output | 1 | Majority-voted bit value |
| bit_strobe | output | 1 | One-cycle pulse marking a valid `bit_value` |

## Verification
The bench drives a low stretch one cycle short of the break threshold and then one exactly at it. An off-by-one in the low counter shows up as a missing break or a spurious one. Two synch bytes whose totals differ only in bit 2 check the rounding; truncating or rounding on the wrong bit gives a period one clock too low or too high. One synch byte has a stretched pair of bits; it must raise the error, keep the old period, and ignore a later synch byte that has no break in front of it. Two low cells end between sub-samples 9 and 10 and between sub-samples 8 and 9; voting on the wrong sub-samples flips one of the two results.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
    localparam int unsigned BRK_MIN_BITS = 11;  // minimum low time of a break, in bits
    localparam int unsigned SYNC_IVALS   = 4;   // falling-edge intervals timed in the synch byte
    localparam int unsigned OVS_LOG      = 4;   // log2 of sub-samples per bit
    localparam int unsigned VOTE_FIRST   = 8;   // first voting sub-sample
    localparam int unsigned VOTE_N       = 3;   // number of voting sub-samples

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_LOW,
        HS_DELIM,
        HS_SYNC
    } hdr_state_e;
endpackage

// File: rtl/lin_break_sync.sv
module lin_break_sync
    import lin_hdr_pkg::*;
#(
    parameter int unsigned PW = 16,
    parameter int unsigned CW = PW + 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_s,
    input  logic          fall,
    input  logic [PW-1:0] nominal_period,
    input  logic          adapt_en,
    output logic          break_detected,
    output logic          sync_done,
    output logic          sync_error,
    output logic [PW-1:0] measured_period
);
    localparam int unsigned IW = $clog2(SYNC_IVALS);
    localparam int unsigned WW = CW + 3;

    typedef struct packed {
        hdr_state_e                   st;
        logic [CW-1:0]                cnt;
        logic [IW-1:0]                idx;
        logic [SYNC_IVALS-1:0][CW-1:0] iv;
        logic                         brk;
        logic                         done;
        logic                         err;
        logic [PW-1:0]                meas;
    } bs_t;

    bs_t q, d;
    logic [WW-1:0] total, tol, ivx4, diff, brk_min;
    logic [CW-1:0] cnt_inc;
    logic [PW-1:0] rounded;
    logic          bad;

    always_comb begin
        total = '0;
        for (int i = 0; i < SYNC_IVALS; i++) begin
            if (i == SYNC_IVALS - 1) total = total + WW'(q.cnt);
            else                     total = total + WW'(q.iv[i]);
        end
        tol  = total >> 3;
        bad  = 1'b0;
        ivx4 = '0;
        diff = '0;
        for (int i = 0; i < SYNC_IVALS; i++) begin
            if (i == SYNC_IVALS - 1) ivx4 = WW'(q.cnt) << 2;
            else                     ivx4 = WW'(q.iv[i]) << 2;
            diff = (ivx4 >= total) ? (ivx4 - total) : (total - ivx4);
            if (diff > tol) bad = 1'b1;
        end
        rounded = PW'((total >> 3) + WW'(total[2]));
        brk_min = WW'(nominal_period) * WW'(BRK_MIN_BITS);
        cnt_inc = (q.cnt == '1) ? q.cnt : q.cnt + 1'b1;

        d      = q;
        d.brk  = 1'b0;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            HS_IDLE: begin
                if (fall) begin
                    d.st  = HS_LOW;
                    d.cnt = CW'(1);
                end
            end
            HS_LOW: begin
                if (rx_s) begin
                    d.cnt = '0;
                    if (WW'(q.cnt) >= brk_min) begin
                        d.brk = 1'b1;
                        d.st  = HS_DELIM;
                    end else begin
                        d.st = HS_IDLE;
                    end
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            HS_DELIM: begin
                if (fall) begin
                    d.st  = HS_SYNC;
                    d.cnt = CW'(1);
                    d.idx = '0;
                end
            end
            HS_SYNC: begin
                if (fall) begin
                    if (q.idx == IW'(SYNC_IVALS - 1)) begin
                        d.st  = HS_IDLE;
                        d.cnt = '0;
                        if (bad) begin
                            d.err = 1'b1;
                        end else begin
                            d.done = 1'b1;
                            if (adapt_en) d.meas = rounded;
                        end
                    end else begin
                        d.iv[q.idx] = q.cnt;
                        d.idx       = q.idx + 1'b1;
                        d.cnt       = CW'(1);
                    end
                end else begin
                    d.cnt = cnt_inc;
                end
            end
            default: d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: HS_IDLE, default: '0};
        else        q <= d;
    end

    assign break_detected  = q.brk;
    assign sync_done       = q.done;
    assign sync_error      = q.err;
    assign measured_period = q.meas;
endmodule

// File: rtl/lin_bit_sampler.sv
module lin_bit_sampler
    import lin_hdr_pkg::*;
#(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_s,
    input  logic          fall,
    input  logic [PW-1:0] period,
    output logic          bit_value,
    output logic          bit_strobe
);
    localparam int unsigned KW = OVS_LOG + 1;

    typedef struct packed {
        logic [PW-1:0]     sub;
        logic [OVS_LOG-1:0] k;
        logic [VOTE_N-1:0] votes;
        logic              bitv;
        logic              stb;
    } sp_t;

    sp_t q, d;
    logic [PW-1:0]      div, base, p;
    logic [OVS_LOG-1:0] kb;
    logic [KW-1:0]      kn;

    always_comb begin
        div = period >> OVS_LOG;
        if (div == '0) div = PW'(1);
        base  = fall ? '0 : q.sub;
        kb    = fall ? '0 : q.k;
        p     = base + 1'b1;
        kn    = KW'(kb) + 1'b1;
        d     = q;
        d.stb = 1'b0;
        if (p >= div) begin
            d.sub = '0;
            for (int j = 0; j < VOTE_N; j++) begin
                if (kn == KW'(VOTE_FIRST + j)) d.votes[j] = rx_s;
            end
            if (kn == KW'(1 << OVS_LOG)) begin
                d.stb  = 1'b1;
                d.bitv = (d.votes[0] & d.votes[1]) | (d.votes[0] & d.votes[2]) |
                         (d.votes[1] & d.votes[2]);
                d.k    = '0;
            end else begin
                d.k = kn[OVS_LOG-1:0];
            end
        end else begin
            d.sub = p;
            d.k   = kb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_value  = q.bitv;
    assign bit_strobe = q.stb;
endmodule

// File: rtl/lin_hdr_sync.sv
module lin_hdr_sync
    import lin_hdr_pkg::*;
#(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_in,
    input  logic [PW-1:0] nominal_period,
    input  logic          adapt_en,
    output logic          break_detected,
    output logic [PW-1:0] measured_period,
    output logic          sync_done,
    output logic          sync_error,
    output logic          bit_value,
    output logic          bit_strobe
);
    typedef struct packed {
        logic rx_s;
        logic rx_p;
    } in_t;

    in_t q, d;
    logic          fall;
    logic [PW-1:0] act_period;

    always_comb begin
        d.rx_s = rx_in;
        d.rx_p = q.rx_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rx_s: 1'b1, rx_p: 1'b1};
        else        q <= d;
    end

    assign fall       = q.rx_p & ~q.rx_s;
    assign act_period = (adapt_en && measured_period != '0) ? measured_period : nominal_period;

    lin_break_sync #(.PW(PW)) u_brk (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_s           (q.rx_s),
        .fall           (fall),
        .nominal_period (nominal_period),
        .adapt_en       (adapt_en),
        .break_detected (break_detected),
        .sync_done      (sync_done),
        .sync_error     (sync_error),
        .measured_period(measured_period)
    );

    lin_bit_sampler #(.PW(PW)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_s      (q.rx_s),
        .fall      (fall),
        .period    (act_period),
        .bit_value (bit_value),
        .bit_strobe(bit_strobe)
    );
endmodule

// File: rtl/lin_hdr_sync_chk.sv
module lin_hdr_sync_chk #(
    parameter int unsigned PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          break_detected,
    input logic [PW-1:0] measured_period,
    input logic          sync_done,
    input logic          sync_error,
    input logic          bit_strobe
);
    AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        break_detected |=> !break_detected); // R1
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_done && sync_error)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> !sync_done); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_error |=> !sync_error); // R6
    AST_ERR_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        sync_error |-> $stable(measured_period)); // R6
    AST_PERIOD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(measured_period) |-> sync_done); // R5
    AST_BRK_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(break_detected && sync_done)); // R3
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> !bit_strobe); // R8
endmodule

bind lin_hdr_sync lin_hdr_sync_chk #(.PW(PW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .break_detected (break_detected),
    .measured_period(measured_period),
    .sync_done      (sync_done),
    .sync_error     (sync_error),
    .bit_strobe     (bit_strobe)
);

// File: tb/lin_hdr_sync_test.sv
module lin_hdr_sync_test;
    localparam int PW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_in = 1'b1;
    logic [PW-1:0] nominal_period = 16'd32;
    logic          adapt_en = 1'b0;
    logic          break_detected, sync_done, sync_error, bit_value, bit_strobe;
    logic [PW-1:0] measured_period;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;
    int brk_cnt = 0, done_cnt = 0, err_cnt = 0;
    bit bitq[$];

    lin_hdr_sync #(.PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .nominal_period(nominal_period),
        .adapt_en(adapt_en), .break_detected(break_detected),
        .measured_period(measured_period), .sync_done(sync_done),
        .sync_error(sync_error), .bit_value(bit_value), .bit_strobe(bit_strobe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    int m_ph, m_cnt, m_idx, m_sub, m_k;
    int m_iv[4];
    bit m_rxs = 1, m_rxp = 1;
    bit m_v[3];
    bit exp_brk, exp_done, exp_err, exp_bit, exp_stb;
    int exp_meas;

    always @(posedge clk) begin
        int tot, ivx, dv, act, dvs, p, kn, kb;
        bit bad, fl;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_sub = 0; m_k = 0;
            m_rxs = 1; m_rxp = 1; exp_brk = 0; exp_done = 0; exp_err = 0;
            exp_bit = 0; exp_stb = 0; exp_meas = 0;
            foreach (m_v[j]) m_v[j] = 0;
            foreach (m_iv[j]) m_iv[j] = 0;
        end else begin
            fl = m_rxp && !m_rxs;
            tot = 0;
            for (int i = 0; i < 4; i++) tot += (i == 3) ? m_cnt : m_iv[i];
            bad = 0;
            for (int i = 0; i < 4; i++) begin
                ivx = 4 * ((i == 3) ? m_cnt : m_iv[i]);
                dv = (ivx > tot) ? ivx - tot : tot - ivx;
                if (dv > tot / 8) bad = 1;
            end
            act = (adapt_en && exp_meas != 0) ? exp_meas : int'(nominal_period);
            exp_brk = 0; exp_done = 0; exp_err = 0;
            case (m_ph)
                0: if (fl) begin m_ph = 1; m_cnt = 1; end
                1: if (m_rxs) begin
                       if (m_cnt >= 11 * int'(nominal_period)) begin exp_brk = 1; m_ph = 2; end
                       else m_ph = 0;
                       m_cnt = 0;
                   end else m_cnt++;
                2: if (fl) begin m_ph = 3; m_cnt = 1; m_idx = 0; end
                default: if (fl) begin
                       if (m_idx == 3) begin
                           m_ph = 0; m_cnt = 0;
                           if (bad) exp_err = 1;
                           else begin
                               exp_done = 1;
                               if (adapt_en) exp_meas = tot / 8 + ((tot >> 2) & 1);
                           end
                       end else begin
                           m_iv[m_idx] = m_cnt; m_idx++; m_cnt = 1;
                       end
                   end else m_cnt++;
            endcase
            dvs = act / 16; if (dvs == 0) dvs = 1;
            p = (fl ? 0 : m_sub) + 1;
            kb = fl ? 0 : m_k;
            exp_stb = 0;
            if (p >= dvs) begin
                m_sub = 0; kn = kb + 1;
                if (kn >= 8 && kn <= 10) m_v[kn - 8] = m_rxs;
                if (kn == 16) begin
                    exp_stb = 1;
                    exp_bit = (m_v[0] & m_v[1]) | (m_v[0] & m_v[2]) | (m_v[1] & m_v[2]);
                    m_k = 0;
                end else m_k = kn;
            end else begin
                m_sub = p; m_k = kb;
            end
            m_rxp = m_rxs; m_rxs = rx_in;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison with the model, plus event counters
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (break_detected !== exp_brk) begin n_fail++;
                $display("FAIL R1 break_detected: actual %0d expected %0d", break_detected, exp_brk); end
            if (sync_done !== exp_done) begin n_fail++;
                $display("FAIL R7 sync_done: actual %0d expected %0d", sync_done, exp_done); end
            if (sync_error !== exp_err) begin n_fail++;
                $display("FAIL R6 sync_error: actual %0d expected %0d", sync_error, exp_err); end
            if (int'(measured_period) != exp_meas) begin n_fail++;
                $display("FAIL R4 measured_period: actual %0d expected %0d", measured_period, exp_meas); end
            if (bit_strobe !== exp_stb) begin n_fail++;
                $display("FAIL R8 bit_strobe: actual %0d expected %0d", bit_strobe, exp_stb); end
            if (exp_stb && bit_value !== exp_bit) begin n_fail++;
                $display("FAIL R8 bit_value: actual %0d expected %0d", bit_value, exp_bit); end
            if (break_detected) brk_cnt++;
            if (sync_done) done_cnt++;
            if (sync_error) err_cnt++;
            if (bit_strobe) bitq.push_back(bit_value);
        end
    end

    task automatic hold(bit v, int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    // 0x55 byte, LSB first: start, 1,0,1,0,1,0,1,0, stop; w[] gives each bit's width
    task automatic send_sync(input int w[10]);
        for (int b = 0; b < 10; b++) hold((b == 0) ? 1'b0 : ((b % 2) == 1), w[b]);
        hold(1'b1, 40);
    endtask

    task automatic do_break(int low, int delim);
        hold(1'b0, low);
        hold(1'b1, delim);
    endtask

    initial begin
        int even[10] = '{32, 32, 32, 32, 32, 32, 32, 32, 32, 32};
        int up[10]   = '{36, 36, 36, 36, 36, 40, 36, 36, 36, 36};
        int down[10] = '{36, 36, 36, 36, 36, 39, 36, 36, 36, 36};
        int skew[10] = '{32, 32, 32, 32, 60, 60, 32, 32, 32, 32};
        repeat (5) @(negedge clk);
        // R9: outputs held at zero during reset
        chk("R9", "reset outputs", {break_detected, sync_done, sync_error, bit_value, bit_strobe}, 0);
        chk("R9", "reset period", measured_period, 0);
        rst_n = 1'b1;
        hold(1'b1, 40);

        // R10 / R2: one cycle short of the threshold
        do_break(351, 40);
        chk("R10", "break count after 351 low", brk_cnt, 0);
        send_sync(even);
        chk("R2", "no sync result without break", done_cnt + err_cnt, 0);

        // R1 / R10: exactly at the threshold, adaptation off
        do_break(352, 40);
        chk("R1", "break count after 352 low", brk_cnt, 1);
        send_sync(even);
        chk("R7", "sync done count", done_cnt, 1);
        chk("R5", "period kept with adapt off", measured_period, 0);

        // R3 / R4 / R5: long delimiter, adapt on, rounding up (total 292)
        adapt_en = 1'b1;
        do_break(400, 150);
        send_sync(up);
        chk("R3", "sync after long delimiter", done_cnt, 2);
        chk("R4", "rounded up period", measured_period, 37);

        // R4: rounding down (total 291)
        do_break(400, 20);
        send_sync(down);
        chk("R4", "rounded down period", measured_period, 36);

        // R6: uneven synch byte
        do_break(400, 20);
        send_sync(skew);
        chk("R6", "error count", err_cnt, 1);
        chk("R6", "period after error", measured_period, 36);
        send_sync(even);
        chk("R6", "no result without new break", done_cnt, 3);

        // R8: majority of sub-samples 8,9,10 at 2 clocks per sub-sample
        adapt_en = 1'b0;
        hold(1'b1, 40);
        hold(1'b0, 3); bitq.delete(); hold(1'b0, 15); hold(1'b1, 60);
        chk("R8", "line rises between samples 9 and 10", (bitq.size() > 0) ? int'(bitq[0]) : -1, 0);
        hold(1'b0, 3); bitq.delete(); hold(1'b0, 13); hold(1'b1, 60);
        chk("R8", "line rises between samples 8 and 9", (bitq.size() > 0) ? int'(bitq[0]) : -1, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule